// File: doc/BRIEF.md
# Priority Interrupt Controller with Acknowledge Chain

The controller gathers interrupt requests from a fixed set of devices. Each device carries a 3-bit priority level, 0 lowest and 7 highest, and an enable bit in a mask. Among the requests that are both raised and enabled, the controller finds the highest level. It raises the interrupt line to the CPU only when that level is strictly above the level of the task now running.

The CPU samples the interrupt line at an instruction boundary and answers with a single-cycle acknowledge. The acknowledge travels down a chain in a fixed device order, starting at device 0. The first device that holds a winning request keeps the acknowledge and does not pass it on. That device's vector is placed on the vector bus, and the winning level is presented so that the CPU can raise its own task level to it.

Requests are level signals owned by the devices. The controller never stores them, so only the device can withdraw its request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cpu_irq` is 0, `bus_en` is 0 and `dev_grant` is all zeros.
- R2: A device whose bit in `dev_mask` is 0 cannot raise `cpu_irq` and cannot receive a grant, whatever its level.
- R3: `cpu_irq` goes to 1 one clock after an enabled request with a level strictly greater than `task_lvl` is present. It stays 0 when the best enabled level is equal to or below `task_lvl`.
- R4: On an acknowledge, the enabled requester with the numerically highest level wins. The level of device i is `dev_lvl[3*i +: 3]`.
- R5: Among enabled requesters at the same highest level, the one with the lowest index wins. Index 0 is the first device in the chain.
- R6: `bus_en` is 1 and `bus_vec` carries the winner's vector `dev_vec[8*i +: 8]` only in a cycle in which `cpu_ack` is 1. In every other cycle `bus_en` is 0 and `bus_vec` is 0.
- R7: While `bus_en` is 1, `new_lvl` equals the winner's level. Otherwise it is 0.
- R8: `dev_grant` is one-hot on the winner during an accepted acknowledge, and all zeros otherwise.
- R9: An acknowledge when no enabled request beats `task_lvl` produces no grant and leaves the bus undriven.
- R10: Requests are not held. When a request is withdrawn, `cpu_irq` follows it one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_req | input | N_DEV | Request level from each device |
| dev_mask | input | N_DEV | Per-device enable; 1 allows the device to interrupt |
| dev_lvl | input | N_DEV*3 | Assigned level per device, 3 bits each |
| dev_vec | input | N_DEV*8 | Service-routine vector offered by each device |
| task_lvl | input | 3 | Priority level of the running task |
| cpu_ack | input | 1 | Single-cycle acknowledge from the CPU |
| cpu_irq | output | 1 | Registered interrupt line to the CPU |
| dev_grant | output | N_DEV | Acknowledge kept by the winning device |
| bus_en | output | 1 | Vector bus drive enable |
| bus_vec | output | 8 | Vector on the bus; 0 when not driving |
| new_lvl | output | 3 | Winning level during an accepted acknowledge |

## Verification
The bench first uses a single enabled requester, which shows that the interrupt line and the vector path work at all. It then sets two requesters at different levels, which separates level-based selection from chain position. Two requesters at the same level isolate the tie-break. Further cases put the task level equal to the best request and then one below it, which confirms that the comparison is strict. Masked high-level requesters next to enabled low-level ones show that the mask acts before selection. A request that is withdrawn and acknowledges with no request pending show that nothing is latched.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_DEV = 8,
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV-1:0]       dev_req,
  input  logic [N_DEV-1:0]       dev_mask,
  input  logic [N_DEV*LVL_W-1:0] dev_lvl,
  input  logic [N_DEV*VEC_W-1:0] dev_vec,
  input  logic [LVL_W-1:0]       task_lvl,
  input  logic                   cpu_ack,
  output logic                   cpu_irq,
  output logic [N_DEV-1:0]       dev_grant,
  output logic                   bus_en,
  output logic [VEC_W-1:0]       bus_vec,
  output logic [LVL_W-1:0]       new_lvl
);

  logic [N_DEV-1:0] live, top;
  logic [N_DEV:0]   pass;
  logic [LVL_W-1:0] best_lvl;
  logic             any_live, beats;

  assign live = dev_req & dev_mask;

  always_comb begin
    best_lvl = '0;
    any_live = 1'b0;
    for (int i = 0; i < N_DEV; i++) begin
      if (live[i] && (!any_live || dev_lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = dev_lvl[i*LVL_W +: LVL_W];
        any_live = 1'b1;
      end
    end
  end

  assign beats   = any_live && (best_lvl > task_lvl);
  assign pass[0] = cpu_ack & beats;

  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_chain
      assign top[g]       = live[g] && (dev_lvl[g*LVL_W +: LVL_W] == best_lvl);
      assign dev_grant[g] = pass[g] & top[g];
      assign pass[g+1]    = pass[g] & ~top[g];
    end
  endgenerate

  always_comb begin
    bus_vec = '0;
    for (int i = 0; i < N_DEV; i++)
      if (dev_grant[i]) bus_vec = dev_vec[i*VEC_W +: VEC_W];
  end

  assign bus_en  = |dev_grant;
  assign new_lvl = bus_en ? best_lvl : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cpu_irq <= 1'b0;
    else        cpu_irq <= beats;

  a_r3_irq_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(|(dev_req & dev_mask)));
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_grant));
  a_r2_masked_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_grant & ~dev_mask) == '0);
  a_r6_bus_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> cpu_ack);
  a_r6_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> bus_vec == '0);
  a_r7_level_beats_task: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> new_lvl > task_lvl);

endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] dev_req = '0, dev_mask = '0;
  logic [N*3-1:0] dev_lvl = '0;
  logic [N*8-1:0] dev_vec;
  logic [2:0] task_lvl = '0;
  logic cpu_ack = 0;
  logic cpu_irq, bus_en;
  logic [N-1:0] dev_grant;
  logic [7:0] bus_vec;
  logic [2:0] new_lvl;

  int errors = 0, checks = 0;

  typedef struct {
    string tag;
    logic irq_next;
    logic en;
    logic [7:0] vec;
    logic [2:0] lvl;
    logic [N-1:0] grant;
  } item_t;
  item_t q[$];
  logic prev_irq = 0;
  string prev_tag = "R1";
  logic done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_mask(dev_mask),
    .dev_lvl(dev_lvl), .dev_vec(dev_vec), .task_lvl(task_lvl), .cpu_ack(cpu_ack),
    .cpu_irq(cpu_irq), .dev_grant(dev_grant), .bus_en(bus_en), .bus_vec(bus_vec),
    .new_lvl(new_lvl));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_lvl(int d, int l);
    dev_lvl[d*3 +: 3] = 3'(l);
  endtask

  task automatic step(string tag, logic [N-1:0] req, logic [N-1:0] msk, int tl, logic ack);
    item_t it;
    int w;
    int bl;
    @(posedge clk); #2;
    dev_req = req; dev_mask = msk; task_lvl = 3'(tl); cpu_ack = ack;
    w = -1; bl = -1;
    for (int i = 0; i < N; i++)
      if (req[i] && msk[i] && int'(dev_lvl[i*3 +: 3]) > bl) begin
        bl = int'(dev_lvl[i*3 +: 3]); w = i;
      end
    it.tag = tag;
    it.irq_next = (w >= 0) && (bl > tl);
    it.en = ack && it.irq_next;
    it.vec = it.en ? dev_vec[w*8 +: 8] : 8'h00;
    it.lvl = it.en ? 3'(bl) : 3'd0;
    it.grant = it.en ? (N'(1) << w) : '0;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(prev_tag, "cpu_irq", int'(cpu_irq), int'(prev_irq));
        chk(it.tag, "bus_en", int'(bus_en), int'(it.en));
        chk(it.tag, "bus_vec", int'(bus_vec), int'(it.vec));
        chk(it.tag, "new_lvl", int'(new_lvl), int'(it.lvl));
        chk(it.tag, "dev_grant", int'(dev_grant), int'(it.grant));
        prev_irq = it.irq_next;
        prev_tag = it.tag;
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) dev_vec[i*8 +: 8] = 8'hA0 + 8'(i);
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "cpu_irq in reset", int'(cpu_irq), 0);
    chk("R1", "bus_en in reset", int'(bus_en), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "cpu_irq after reset", int'(cpu_irq), 0);
    chk("R1", "dev_grant after reset", int'(dev_grant), 0);

    for (int i = 0; i < N; i++) set_lvl(i, 1);
    set_lvl(3, 5);
    step("R3", 8'h08, 8'hFF, 2, 0);
    step("R6", 8'h08, 8'hFF, 2, 1);
    step("R6", 8'h08, 8'hFF, 2, 0);
    step("R2", 8'h08, 8'hF7, 0, 0);
    step("R9", 8'h08, 8'hF7, 0, 1);
    set_lvl(1, 3); set_lvl(5, 6);
    step("R4", 8'h22, 8'hFF, 0, 0);
    step("R7", 8'h22, 8'hFF, 0, 1);
    set_lvl(2, 4); set_lvl(6, 4);
    step("R5", 8'h44, 8'hFF, 1, 0);
    step("R8", 8'h44, 8'hFF, 1, 1);
    step("R3", 8'h44, 8'hFF, 4, 0);
    step("R9", 8'h44, 8'hFF, 4, 1);
    step("R3", 8'h44, 8'hFF, 3, 1);
    step("R10", 8'h00, 8'hFF, 0, 0);
    step("R10", 8'h00, 8'hFF, 0, 1);
    step("R2", 8'h22, 8'hDF, 0, 1);
    step("R2", 8'hFF, 8'h00, 0, 1);
    step("R4", 8'hFF, 8'hFF, 0, 1);
    step("R10", 8'h00, 8'h00, 0, 0);
    step("R1", 8'h00, 8'h00, 0, 0);
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule